// File: doc/BRIEF.md
# MCLK-to-Frame Ratio Detector and Phase Resynchronizer

This block sits on the master-clock side of a slave-mode audio serial port. It counts master-clock cycles between rising edges of the frame (word-select) clock. Each count is then sorted into one of six supported oversampling ratios: 128, 192, 256, 384, 512 or 768 master clocks per sample. The ratio is declared locked once two back-to-back counts land in the same class. A count that fits no class raises an invalid flag and drops lock.

Alongside the ratio detection, the block keeps its own frame position in bit-clock units. At every frame edge it compares that position with where the external frame edge actually arrived. The external and internal timing may start in any phase. After the first frame edge aligns the internal count, small wander is tolerated. If the error exceeds a window measured in bit clocks, the block emits a one-cycle resynchronize pulse and realigns. The sample path downstream may then repeat or lose one sample.

Both serial clocks arrive asynchronously. Each passes through a two-flop synchronizer before its edges are detected.

Top module: `clk_ratio_tracker`

## Requirements
- R1: While reset is asserted, `locked`, `ratio_bad` and `resync` are 0 and `ratio_code` is 0.
- R2: A measurement is the number of `clk` cycles between two consecutive rising edges of `lrclk_in`. The first rising edge after reset only starts counting and changes no output. `locked` and `ratio_bad` change only as the result of a measurement.
- R3: A measurement within ±2 cycles of a supported ratio maps to that ratio's code: 0 = 128, 1 = 192, 2 = 256, 3 = 384, 4 = 512, 5 = 768. While `locked` is 1, `ratio_code` is one of these codes.
- R4: `locked` rises, and `ratio_code` takes the class, when two consecutive measurements fall in the same class. This happens on the fourth rising `clk` edge, counting from the edge that first samples `lrclk_in` high. While `locked` stays 1, `ratio_code` does not change.
- R5: A measurement outside every window sets `ratio_bad` to 1 and `locked` to 0. The next in-window measurement clears `ratio_bad`. `ratio_bad` and `locked` are never 1 together.
- R6: If `locked` is 1 and a measurement falls in a different class, `locked` drops. It returns, with the new code, after a second consecutive measurement in that class.
- R7: The internal frame position counts rising edges of `bclk_in` modulo 64. The first `lrclk_in` rising edge after reset resets the position to 0 without a `resync` pulse.
- R8: At each later `lrclk_in` rising edge, the deviation is min(pos, 64 − pos). If it exceeds 8, `resync` is 1 for exactly one cycle, on the third rising `clk` edge counting from the edge that first samples `lrclk_in` high, and the position is reloaded to 0. A deviation of 8 or less gives no pulse and leaves the position untouched.
- R9: A resynchronization leaves `locked` and `ratio_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lrclk_in | input | 1 | Frame clock from the external master, asynchronous |
| bclk_in | input | 1 | Bit clock from the external master, asynchronous |
| ratio_code | output | 3 | Detected ratio class, meaningful while `locked` is 1 |
| locked | output | 1 | Two consecutive measurements agreed on a class |
| resync | output | 1 | One-cycle pulse when the frame phase was realigned |
| ratio_bad | output | 1 | Last measurement matched no supported ratio |

## Verification
Every result is tied to the `clk` edge that first samples a frame-clock rising edge. Two synchronizer stages plus the edge register put `resync` on the third edge. The measurement register adds one more, so `locked` moves on the fourth. The bench records the cycle number when it drives each frame edge. A sampling monitor records the cycle in which `resync` or a rising `locked` is first seen, and these are compared with the drive cycle plus three or four. Status checks are made only after a whole frame has been driven. At that point the outputs must reflect the measurement of the frame before, which is far beyond both latencies.

// File: rtl/rt_pkg.sv
package rt_pkg;

  localparam int unsigned NUM_RATIOS = 6;
  localparam int unsigned CODE_W     = 3;

  typedef logic [CODE_W-1:0] ratio_code_t;

  typedef enum logic [1:0] {
    ACQ_NONE = 2'd0,
    ACQ_CAND = 2'd1,
    ACQ_LOCK = 2'd2
  } acq_state_t;

  // Even indices walk 128 * 2^k, odd indices walk 192 * 2^k.
  function automatic int unsigned ratio_mclks(input int unsigned idx);
    int unsigned base;
    base = ((idx % 2) == 0) ? 128 : 192;
    return base << (idx / 2);
  endfunction

endpackage

// File: rtl/rt_sync2.sv
module rt_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

endmodule

// File: rtl/rt_period_meter.sv
module rt_period_meter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] meas_q, meas_n;
  logic             have_ref_q, have_ref_n;
  logic             vld_q, vld_n;
  logic [CNT_W-1:0] cnt_inc;

  // Saturating increment so a missing frame clock never aliases to a ratio.
  assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_comb begin
    cnt_n      = cnt_inc;
    meas_n     = meas_q;
    have_ref_n = have_ref_q;
    vld_n      = 1'b0;
    if (edge_i) begin
      cnt_n      = '0;
      have_ref_n = 1'b1;
      vld_n      = have_ref_q;
      if (have_ref_q) begin
        meas_n = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      meas_q     <= '0;
      have_ref_q <= 1'b0;
      vld_q      <= 1'b0;
    end else begin
      cnt_q      <= cnt_n;
      meas_q     <= meas_n;
      have_ref_q <= have_ref_n;
      vld_q      <= vld_n;
    end
  end

  assign meas_vld = vld_q;
  assign meas     = meas_q;

endmodule

// File: rtl/rt_ratio_lock.sv
module rt_ratio_lock
  import rt_pkg::*;
#(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned MATCH_TOL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_vld,
  input  logic [CNT_W-1:0] meas,
  output ratio_code_t      ratio_code,
  output logic             locked,
  output logic             ratio_bad
);

  logic [31:0]           meas_w;
  logic [NUM_RATIOS-1:0] hit_vec;
  logic                  hit;
  ratio_code_t           hit_code;

  assign meas_w = {{(32-CNT_W){1'b0}}, meas};

  // One acceptance window per supported ratio.
  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
    localparam int unsigned CENTER = ratio_mclks(i);
    localparam int unsigned LO     = CENTER - MATCH_TOL;
    localparam int unsigned HI     = CENTER + MATCH_TOL;
    assign hit_vec[i] = (meas_w >= 32'(LO)) && (meas_w <= 32'(HI));
  end

  always_comb begin
    hit      = |hit_vec;
    hit_code = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (hit_vec[i]) begin
        hit_code = ratio_code_t'(i);
      end
    end
  end

  acq_state_t  st_q, st_n;
  ratio_code_t cand_q, cand_n;
  ratio_code_t code_q, code_n;
  logic        bad_q, bad_n;

  always_comb begin
    st_n   = st_q;
    cand_n = cand_q;
    code_n = code_q;
    bad_n  = bad_q;
    if (meas_vld) begin
      if (!hit) begin
        st_n  = ACQ_NONE;
        bad_n = 1'b1;
      end else begin
        bad_n  = 1'b0;
        cand_n = hit_code;
        if ((st_q != ACQ_NONE) && (cand_q == hit_code)) begin
          st_n   = ACQ_LOCK;
          code_n = hit_code;
        end else begin
          st_n = ACQ_CAND;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ACQ_NONE;
      cand_q <= '0;
      code_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cand_q <= cand_n;
      code_q <= code_n;
      bad_q  <= bad_n;
    end
  end

  assign ratio_code = code_q;
  assign locked     = (st_q == ACQ_LOCK);
  assign ratio_bad  = bad_q;

endmodule

// File: rtl/rt_phase_track.sv
module rt_phase_track #(
  parameter int unsigned FRAME_BCLKS = 64,
  parameter int unsigned PHASE_TOL   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_rise,
  input  logic lr_rise,
  output logic resync
);

  localparam int unsigned POS_W = $clog2(FRAME_BCLKS);
  localparam int unsigned HALF  = FRAME_BCLKS / 2;

  logic [POS_W-1:0] pos_q, pos_n;
  logic             armed_q, armed_n;
  logic             pulse_q, pulse_n;
  logic [POS_W:0]   pos_ext;
  logic [POS_W:0]   dev;
  logic             too_far;
  logic [POS_W-1:0] pos_inc;

  assign pos_ext = {1'b0, pos_q};
  assign dev     = (pos_ext < (POS_W+1)'(HALF)) ? pos_ext
                                                : (POS_W+1)'(FRAME_BCLKS) - pos_ext;
  assign too_far = dev > (POS_W+1)'(PHASE_TOL);
  assign pos_inc = (pos_q == POS_W'(FRAME_BCLKS-1)) ? '0 : pos_q + 1'b1;

  always_comb begin
    pos_n   = pos_q;
    armed_n = armed_q;
    pulse_n = 1'b0;
    if (lr_rise && (!armed_q || too_far)) begin
      pos_n   = '0;
      armed_n = 1'b1;
      pulse_n = armed_q;
    end else if (bclk_rise) begin
      pos_n = pos_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pos_q   <= pos_n;
      armed_q <= armed_n;
      pulse_q <= pulse_n;
    end
  end

  assign resync = pulse_q;

endmodule

// File: rtl/clk_ratio_tracker.sv
module clk_ratio_tracker #(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned MATCH_TOL   = 2,
  parameter int unsigned FRAME_BCLKS = 64,
  parameter int unsigned PHASE_TOL   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lrclk_in,
  input  logic       bclk_in,
  output logic [2:0] ratio_code,
  output logic       locked,
  output logic       resync,
  output logic       ratio_bad
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_pipe_q[1];

  // Serial clocks into this domain.
  logic [1:0] pins_sync;

  rt_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     ({lrclk_in, bclk_in}),
    .q     (pins_sync)
  );

  logic lr_d_q, bclk_d_q;
  logic lr_rise, bclk_rise;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      lr_d_q   <= 1'b0;
      bclk_d_q <= 1'b0;
    end else begin
      lr_d_q   <= pins_sync[1];
      bclk_d_q <= pins_sync[0];
    end
  end

  assign lr_rise   = pins_sync[1] & ~lr_d_q;
  assign bclk_rise = pins_sync[0] & ~bclk_d_q;

  logic             meas_vld;
  logic [CNT_W-1:0] meas;

  rt_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .edge_i   (lr_rise),
    .meas_vld (meas_vld),
    .meas     (meas)
  );

  rt_ratio_lock #(.CNT_W(CNT_W), .MATCH_TOL(MATCH_TOL)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .meas_vld   (meas_vld),
    .meas       (meas),
    .ratio_code (ratio_code),
    .locked     (locked),
    .ratio_bad  (ratio_bad)
  );

  rt_phase_track #(.FRAME_BCLKS(FRAME_BCLKS), .PHASE_TOL(PHASE_TOL)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bclk_rise (bclk_rise),
    .lr_rise   (lr_rise),
    .resync    (resync)
  );

endmodule

// File: rtl/rt_checks.sv
module rt_checks (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ratio_code,
  input logic       locked,
  input logic       resync,
  input logic       ratio_bad,
  input logic       lr_rise,
  input logic       meas_vld
);

  assert_resync_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !resync);

  assert_resync_after_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> $past(lr_rise));

  assert_bad_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_bad |-> !locked);

  assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (ratio_code < 3'd6));

  assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> (ratio_code == $past(ratio_code)));

  assert_lock_from_meas_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(meas_vld));

  assert_status_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(meas_vld) |-> ($stable(locked) && $stable(ratio_bad)));

endmodule

bind clk_ratio_tracker rt_checks u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .ratio_code (ratio_code),
  .locked     (locked),
  .resync     (resync),
  .ratio_bad  (ratio_bad),
  .lr_rise    (lr_rise),
  .meas_vld   (meas_vld)
);

// File: tb/sim_clk_ratio_tracker.sv
module sim_clk_ratio_tracker;

  logic       clk;
  logic       rst_n;
  logic       lrclk_in;
  logic       bclk_in;
  logic [2:0] ratio_code;
  logic       locked;
  logic       resync;
  logic       ratio_bad;

  clk_ratio_tracker u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .lrclk_in   (lrclk_in),
    .bclk_in    (bclk_in),
    .ratio_code (ratio_code),
    .locked     (locked),
    .resync     (resync),
    .ratio_bad  (ratio_bad)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nvec = 0;
  int nbad = 0;
  int rise_cyc = 0;
  bit finished = 0;

  // Monitor sampled away from the active edge.
  int resync_hi = 0;
  int last_resync_cyc = -1;
  int lock_rise_cyc = -1;
  bit prev_lock = 0;
  always @(negedge clk) begin
    if (resync === 1'b1) begin
      resync_hi = resync_hi + 1;
      last_resync_cyc = cyc;
    end
    if (locked === 1'b1 && !prev_lock) lock_rise_cyc = cyc;
    prev_lock = (locked === 1'b1);
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lrclk_in = 1'b0;
    bclk_in = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1 locked in reset", int'(locked), 0);
    check_eq("R1 ratio_bad in reset", int'(ratio_bad), 0);
    check_eq("R1 resync in reset", int'(resync), 0);
    check_eq("R1 ratio_code in reset", int'(ratio_code), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // One frame: 64 bit slots of d clk cycles; frame clock high for slots 0..31.
  // The first drop_n bit-clock pulses are suppressed; extra > 0 appends idle
  // cycles, extra < 0 shortens the last slot.
  task automatic gen_frame(input int d, input int drop_n, input int extra);
    for (int b = 0; b < 64; b++) begin
      int slot;
      slot = (b == 63 && extra < 0) ? d + extra : d;
      for (int j = 0; j < slot; j++) begin
        @(negedge clk);
        if (b == 0 && j == 0) rise_cyc = cyc;
        lrclk_in = (b < 32);
        bclk_in  = (j >= d / 2) && (b >= drop_n);
      end
    end
    if (extra > 0) begin
      for (int k = 0; k < extra; k++) begin
        @(negedge clk);
        lrclk_in = 1'b0;
        bclk_in  = 1'b0;
      end
    end
  endtask

  task automatic frames(input int n, input int d, input int extra);
    for (int k = 0; k < n; k++) gen_frame(d, 0, extra);
  endtask

  initial begin
    int base;
    rst_n = 1'b1;
    lrclk_in = 1'b0;
    bclk_in = 1'b0;

    // R1..R4, R7: every supported ratio from reset.
    for (int i = 0; i < 6; i++) begin
      int d;
      d = (((i % 2) == 0) ? 128 : 192) * (1 << (i / 2)) / 64;
      do_reset();
      base = resync_hi;
      gen_frame(d, 0, 0);
      check_eq("R2 no status after first edge", int'(locked) + int'(ratio_bad), 0);
      gen_frame(d, 0, 0);
      check_eq("R4 single measurement not locked", int'(locked), 0);
      gen_frame(d, 0, 0);
      check_eq("R4 lock latency", lock_rise_cyc - rise_cyc, 4);
      check_eq("R4 locked", int'(locked), 1);
      check_eq("R3 code", int'(ratio_code), i);
      check_eq("R5 no bad", int'(ratio_bad), 0);
      gen_frame(d, 0, 0);
      check_eq("R4 still locked", int'(locked), 1);
      check_eq("R7 first edge silent", resync_hi - base, 0);
    end

    // R6: class change from 768 to 256.
    gen_frame(4, 0, 0);
    check_eq("R6 old class still locked", int'(locked), 1);
    gen_frame(4, 0, 0);
    check_eq("R6 lock dropped", int'(locked), 0);
    gen_frame(4, 0, 0);
    check_eq("R6 relocked", int'(locked), 1);
    check_eq("R6 new code", int'(ratio_code), 2);

    // R3 window edges, R5 out-of-window.
    do_reset(); frames(3, 4, 2);
    check_eq("R3 258 locked", int'(locked), 1);
    check_eq("R3 258 code", int'(ratio_code), 2);
    do_reset(); frames(3, 4, -2);
    check_eq("R3 254 locked", int'(locked), 1);
    check_eq("R3 254 code", int'(ratio_code), 2);
    do_reset();
    gen_frame(4, 0, 3);
    check_eq("R2 259 no status yet", int'(ratio_bad), 0);
    gen_frame(4, 0, 3);
    check_eq("R5 259 bad", int'(ratio_bad), 1);
    check_eq("R5 259 unlocked", int'(locked), 0);
    do_reset(); frames(3, 4, -3);
    check_eq("R5 253 bad", int'(ratio_bad), 1);
    check_eq("R5 253 unlocked", int'(locked), 0);

    // R5: unsupported 320 then recovery; also drop of an existing lock.
    do_reset(); frames(3, 4, 0);
    check_eq("R5 pre lock", int'(locked), 1);
    frames(2, 5, 0);
    check_eq("R5 320 bad", int'(ratio_bad), 1);
    check_eq("R5 320 drops lock", int'(locked), 0);
    gen_frame(4, 0, 0);
    check_eq("R5 still bad", int'(ratio_bad), 1);
    gen_frame(4, 0, 0);
    check_eq("R5 bad cleared", int'(ratio_bad), 0);
    check_eq("R5 not yet locked", int'(locked), 0);
    gen_frame(4, 0, 0);
    check_eq("R5 relocked", int'(locked), 1);

    // R8, R9: phase deviation boundaries.
    do_reset(); frames(3, 4, 0);
    base = resync_hi;
    gen_frame(4, 8, 0);
    gen_frame(4, 0, 0);
    check_eq("R8 deviation 8 tolerated", resync_hi - base, 0);
    gen_frame(4, 1, 0);
    gen_frame(4, 0, 0);
    check_eq("R8 deviation 9 one pulse", resync_hi - base, 1);
    check_eq("R8 resync latency", last_resync_cyc - rise_cyc, 3);
    check_eq("R9 lock kept", int'(locked), 1);
    check_eq("R9 code kept", int'(ratio_code), 2);
    gen_frame(4, 0, 0);
    check_eq("R8 reloaded", resync_hi - base, 1);
    gen_frame(4, 56, 0);
    gen_frame(4, 0, 0);
    check_eq("R8 lead 8 tolerated", resync_hi - base, 1);
    gen_frame(4, 63, 0);
    gen_frame(4, 0, 0);
    check_eq("R8 lead 9 pulse", resync_hi - base, 2);
    check_eq("R8 resync latency lead", last_resync_cyc - rise_cyc, 3);
    check_eq("R9 lock after lead", int'(locked), 1);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule